// File: doc/BRIEF.md
# Lane Test Sequence Checker

This block watches one serial lane after symbol alignment and judges whether the arriving characters follow a chosen repeating link-layer test sequence. It offers three sequence checks and one error-count mode. One check looks at raw 10-bit codes for a steady high-frequency pattern, used in random-jitter work. A second looks at raw codes for a mixed-frequency comma pattern, used in deterministic-jitter work. The third follows a repeating lane alignment sequence on decoded characters. The 8b/10b decoder sits upstream and supplies the decoded octet, its control flag, and the code-error and disparity-error flags.

There are two results. The sticky alarm reads 1 for fail and 0 for pass. An error counter collects decoder errors over a test interval, so software can estimate the bit error rate while a random or jitter-tolerance pattern runs. A synchronous clear input starts a new test: it drops the alarm, empties the counter and resets the sequence trackers.

Top module: `lane_seq_chk`

## Requirements
- R1: After reset, `alarm` is 0 and `err_cnt` is 0.
- R2: With `mode` = 0, every valid symbol whose 10-bit `sym` differs from 1010101010 sets `alarm` on the next clock edge. A stream of matching symbols leaves it at 0.
- R3: With `mode` = 1, the first valid symbol after reset or clear must be 0011111010 or 1100000101, and that symbol fixes the phase. Each later valid symbol must be the other code from the one before it. Any other value, or the same code twice in a row, sets `alarm`.
- R4: With `mode` = 2, valid octets are counted in multiframes of FRAME_OCTETS*MF_FRAMES octets (at least 3), and the count restarts after ILA_MFS multiframes. Octet 0 must be control character 0x1C (`chr_k`=1). The last octet must be control 0x7C. Octet 1 of multiframe 1 must be control 0x9C. Every other octet must carry `chr_k`=0. Any deviation sets `alarm`.
- R5: A valid symbol that has `code_err` or `disp_err` set sets `alarm`, in every mode.
- R6: With `mode` = 3, each valid symbol that has `code_err` or `disp_err` set adds exactly 1 to `err_cnt`. Sequence mismatches are not checked in this mode. In modes 0 to 2, `err_cnt` does not change.
- R7: `err_cnt` stops at its all-ones value and does not wrap.
- R8: `alarm` stays at 1 until `clr` is asserted. `clr` clears `alarm`, `err_cnt` and the sequence trackers on the next edge, and it takes precedence over a symbol presented in the same cycle.
- R9: When `sym_vld` is 0, the inputs are ignored. `alarm` and `err_cnt` hold, and the sequence position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous test clear |
| mode | input | 2 | 0 high-freq, 1 comma, 2 alignment, 3 error count |
| sym_vld | input | 1 | Character valid |
| sym | input | 10 | Raw aligned 10-bit code |
| chr | input | 8 | Decoded octet |
| chr_k | input | 1 | Decoded octet is a control character |
| code_err | input | 1 | Decoder reports an invalid code |
| disp_err | input | 1 | Decoder reports a disparity error |
| alarm | output | 1 | Sticky fail flag |
| err_cnt | output | CNT_W | Saturating decoder error count |

## Verification
The bench builds the checker with CNT_W = 4, FRAME_OCTETS = 2 and MF_FRAMES = 2. A 4-bit counter reaches saturation after fifteen errored symbols. A four-octet multiframe lets two complete alignment cycles run in a few dozen symbols, each cycle having four multiframes with the special octet in the second one. Because the multiframe is this short, start, end and special-octet faults can each be injected at a known position.

// File: rtl/lane_seq_chk.sv
`timescale 1ns/1ps
module lane_seq_chk #(
  parameter int CNT_W        = 32,
  parameter int FRAME_OCTETS = 4,
  parameter int MF_FRAMES    = 8,
  parameter int ILA_MFS      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [1:0]       mode,
  input  logic             sym_vld,
  input  logic [9:0]       sym,
  input  logic [7:0]       chr,
  input  logic             chr_k,
  input  logic             code_err,
  input  logic             disp_err,
  output logic             alarm,
  output logic [CNT_W-1:0] err_cnt
);
  localparam int MF_LEN = FRAME_OCTETS * MF_FRAMES;
  localparam int POS_W  = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
  localparam int MFI_W  = (ILA_MFS > 1) ? $clog2(ILA_MFS) : 1;
  localparam logic [9:0] HF_CODE = 10'b1010101010;
  localparam logic [9:0] CM_NEG  = 10'b0011111010;
  localparam logic [9:0] CM_POS  = 10'b1100000101;
  localparam logic [7:0] MF_HEAD = 8'h1C;
  localparam logic [7:0] MF_TAIL = 8'h7C;
  localparam logic [7:0] MF_MARK = 8'h9C;

  logic             cm_run, cm_want_pos;
  logic [POS_W-1:0] pos;
  logic [MFI_W-1:0] mfi;
  logic             al_bad, mism;

  wire is_neg   = (sym == CM_NEG);
  wire is_pos   = (sym == CM_POS);
  wire cm_bad   = cm_run ? (cm_want_pos ? !is_pos : !is_neg) : !(is_neg || is_pos);
  wire pos_last = (pos == POS_W'(MF_LEN - 1));
  wire mfi_last = (mfi == MFI_W'(ILA_MFS - 1));
  wire dec_err  = code_err || disp_err;
  wire cnt_full = &err_cnt;

  always_comb begin
    if (pos == '0)                                        al_bad = !(chr_k && chr == MF_HEAD);
    else if (pos_last)                                    al_bad = !(chr_k && chr == MF_TAIL);
    else if (mfi == MFI_W'(1) && pos == POS_W'(1))        al_bad = !(chr_k && chr == MF_MARK);
    else                                                  al_bad = chr_k;
  end

  always_comb begin
    case (mode)
      2'd0:    mism = (sym != HF_CODE);
      2'd1:    mism = cm_bad;
      2'd2:    mism = al_bad;
      default: mism = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm <= 1'b0; err_cnt <= '0;
      cm_run <= 1'b0; cm_want_pos <= 1'b0; pos <= '0; mfi <= '0;
    end else if (clr) begin
      alarm <= 1'b0; err_cnt <= '0;
      cm_run <= 1'b0; cm_want_pos <= 1'b0; pos <= '0; mfi <= '0;
    end else if (sym_vld) begin
      if (mism || dec_err) alarm <= 1'b1;
      if (mode == 2'd3 && dec_err && !cnt_full) err_cnt <= err_cnt + 1'b1;
      if (mode == 2'd1) begin
        cm_run      <= 1'b1;
        cm_want_pos <= cm_run ? !cm_want_pos : is_neg;
      end
      if (mode == 2'd2) begin
        if (pos_last) begin
          pos <= '0;
          mfi <= mfi_last ? '0 : mfi + 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !clr) |=> alarm);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!alarm && err_cnt == '0));
  p_dec_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld && dec_err && !clr) |=> alarm);
  p_cnt_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mode != 2'd3) |=> $stable(err_cnt));
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_full && !clr) |=> (&err_cnt));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_vld && !clr) |=> ($stable(alarm) && $stable(err_cnt) && $stable(pos) && $stable(mfi)));
endmodule

// File: tb/lane_seq_chk_bench.sv
`timescale 1ns/1ps
module lane_seq_chk_bench;
  localparam int CW = 4;
  localparam logic [9:0] HF = 10'b1010101010, CN = 10'b0011111010, CP = 10'b1100000101;

  logic clk = 0, rst_n = 0, clr = 0, sym_vld = 0, chr_k = 0, code_err = 0, disp_err = 0;
  logic [1:0] mode = 0;
  logic [9:0] sym = 0;
  logic [7:0] chr = 0;
  logic alarm;
  logic [CW-1:0] err_cnt;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [CW:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  lane_seq_chk #(.CNT_W(CW), .FRAME_OCTETS(2), .MF_FRAMES(2), .ILA_MFS(4)) u_lane_seq_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .sym_vld(sym_vld), .sym(sym),
    .chr(chr), .chr_k(chr_k), .code_err(code_err), .disp_err(disp_err),
    .alarm(alarm), .err_cnt(err_cnt));

  task automatic apply(input logic [1:0] md, input logic v, input logic [9:0] s,
                       input logic [7:0] c, input logic k, input logic ce, input logic de,
                       input logic cl, input logic ea, input int ec, input string tag);
    @(negedge clk);
    mode = md; sym_vld = v; sym = s; chr = c; chr_k = k;
    code_err = ce; disp_err = de; clr = cl;
    exp_q.push_back({ea, CW'(ec)});
    tag_q.push_back(tag);
  endtask

  task automatic clear(input logic [1:0] md);
    apply(md, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
  endtask

  task automatic ila_ok(input int m, input int p, input int ec, input logic ea);
    logic [7:0] c; logic k;
    if (p == 0) begin c = 8'h1C; k = 1; end
    else if (p == 3) begin c = 8'h7C; k = 1; end
    else if (m == 1 && p == 1) begin c = 8'h9C; k = 1; end
    else begin c = 8'h55; k = 0; end
    apply(2, 1, 0, c, k, 0, 0, 0, ea, ec, "R4");
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [CW:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (alarm !== e[CW] || err_cnt !== e[CW-1:0]) begin
        fails++;
        $display("FAIL %s: alarm=%0b err_cnt=%0d expected alarm=%0b err_cnt=%0d",
                 t, alarm, err_cnt, e[CW], e[CW-1:0]);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    apply(0, 0, 10'h3FF, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2 high-frequency pattern
    for (int i = 0; i < 4; i++) apply(0, 1, HF, 0, 0, 0, 0, 0, 0, 0, "R2");
    apply(0, 1, 10'b1010101011, 0, 0, 0, 0, 0, 1, 0, "R2");
    apply(0, 0, HF, 0, 0, 0, 0, 0, 1, 0, "R8");
    clear(0);
    apply(0, 0, 10'h000, 0, 0, 1, 1, 0, 0, 0, "R9");
    apply(0, 1, HF, 0, 0, 1, 0, 0, 1, 0, "R5");
    clear(1);
    // R3 comma alternation, negative start, with an idle gap
    apply(1, 1, CN, 0, 0, 0, 0, 0, 0, 0, "R3");
    apply(1, 0, CN, 0, 0, 0, 0, 0, 0, 0, "R9");
    apply(1, 1, CP, 0, 0, 0, 0, 0, 0, 0, "R3");
    apply(1, 1, CN, 0, 0, 0, 0, 0, 0, 0, "R3");
    apply(1, 1, CP, 0, 0, 0, 0, 0, 0, 0, "R3");
    apply(1, 1, CP, 0, 0, 0, 0, 0, 1, 0, "R3");
    clear(1);
    apply(1, 1, CP, 0, 0, 0, 0, 0, 0, 0, "R3");
    apply(1, 1, CN, 0, 0, 0, 0, 0, 0, 0, "R3");
    apply(1, 1, CP, 0, 0, 0, 0, 0, 0, 0, "R3");
    apply(1, 1, 10'h000, 0, 0, 0, 0, 0, 1, 0, "R3");
    clear(1);
    apply(1, 1, HF, 0, 0, 0, 0, 0, 1, 0, "R3");
    clear(2);
    // R4 alignment sequence: two full cycles with a gap
    for (int r = 0; r < 2; r++)
      for (int m = 0; m < 4; m++)
        for (int p = 0; p < 4; p++) begin
          ila_ok(m, p, 0, 0);
          if (r == 0 && m == 2 && p == 1) apply(2, 0, 0, 8'h1C, 1, 0, 0, 0, 0, 0, "R9");
        end
    clear(2);
    ila_ok(0, 0, 0, 0);
    apply(2, 1, 0, 8'h9C, 1, 0, 0, 0, 1, 0, "R4");
    clear(2);
    for (int p = 0; p < 4; p++) ila_ok(0, p, 0, 0);
    ila_ok(1, 0, 0, 0);
    apply(2, 1, 0, 8'h9C, 0, 0, 0, 0, 1, 0, "R4");
    clear(2);
    for (int p = 0; p < 3; p++) ila_ok(0, p, 0, 0);
    apply(2, 1, 0, 8'h7C, 0, 0, 0, 0, 1, 0, "R4");
    clear(0);
    apply(0, 1, HF, 0, 0, 1, 1, 0, 1, 0, "R6");
    clear(3);
    // R6 counting, R7 saturation
    apply(3, 1, 10'h000, 0, 0, 0, 0, 0, 0, 0, "R6");
    apply(3, 1, 0, 0, 0, 1, 0, 0, 1, 1, "R6");
    apply(3, 1, 0, 0, 0, 0, 1, 0, 1, 2, "R6");
    apply(3, 1, 0, 0, 0, 1, 1, 0, 1, 3, "R6");
    apply(3, 0, 0, 0, 0, 1, 1, 0, 1, 3, "R9");
    apply(3, 1, HF, 0, 0, 0, 0, 0, 1, 3, "R6");
    for (int n = 4; n < 20; n++)
      apply(3, 1, 0, 0, 0, 1, 0, 0, 1, (n > 15) ? 15 : n, "R7");
    apply(3, 1, 0, 0, 0, 1, 0, 1, 0, 0, "R8");
    apply(3, 1, 0, 0, 0, 1, 0, 0, 1, 1, "R6");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule